// File: doc/BRIEF.md
# Class-Aware Home Slice Selector

Each tile of a 4x4 tiled processor has a last-level cache slice, and the slices are joined by a 2-D folded torus. When a core misses in its first-level cache, this block decides which single slice to send the request to. It takes the miss address, the access class, the tile's own coordinates, and a request strobe. One cycle later it gives the destination tile coordinates with a valid flag. It sends exactly one probe: there is no broadcast and no second lookup.

The placement depends on the access class. Private data stays in the requester's own slice. Shared data is spread over all sixteen slices by the address bits just above the set index. Instruction blocks are replicated at cluster granularity. Each tile sees a four-tile cluster made of itself, its right and left neighbours, and the tile above it. Inside that cluster the block's home is chosen by adding the tile's rotational ID to two address bits. Clusters overlap, but a given instruction block always lands on a tile whose rotational ID is fixed by the address. Any requester therefore finds its copy at most one hop away, with a single probe.

The rotational ID is computed from the coordinates and is also driven out on a port.

Top module: `slice_home_picker`

## Requirements
- R1: After reset, `dst_valid`, `dst_x` and `dst_y` are 0. `dst_valid` is 1 in exactly the cycle after a cycle with `req_valid` high, and 0 otherwise.
- R2: A request with class code 2'b01 (private data) gets a destination equal to the requester's own `tile_x`/`tile_y`.
- R3: A request with class code 2'b10 (shared data) gets `dst_x` = `req_addr[17:16]` and `dst_y` = `req_addr[19:18]`. Bits 5:0 are the block offset and bits 15:6 are the set index.
- R4: A request with class code 2'b00 (instruction) computes R = (`req_addr[17:16]` + `rid_out` + 1) mod 4. The destination is then chosen from R as follows, with wrap-around at every edge:
  - 0: the own tile.
  - 1: x+1 mod 4.
  - 2: y-1 mod 4 (the tile above).
  - 3: x-1 mod 4.
- R5: For any instruction request, the rotational ID of the destination tile, (2*dst_y - dst_x) mod 4, equals 3 - `req_addr[17:16]` mod 4. The destination is never more than one torus hop from the requester.
- R6: `rid_out` equals (2*`tile_y` - `tile_x`) mod 4 combinationally. It therefore steps by 1 between row neighbours and by 2 between column neighbours.
- R7: Class code 2'b11 is routed exactly as shared data.
- R8: While `req_valid` is low, `dst_x` and `dst_y` keep their last values, whatever the other inputs do.
- R9: Address bits other than 19:16 have no effect on the destination for any class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request strobe |
| req_addr | input | 42 | Physical miss address |
| req_class | input | 2 | 00 instruction, 01 private, 10 shared, 11 treated as shared |
| tile_x | input | 2 | Requester column |
| tile_y | input | 2 | Requester row |
| rid_out | output | 2 | Rotational ID of this tile |
| dst_valid | output | 1 | Destination valid, one cycle after request |
| dst_x | output | 2 | Destination column |
| dst_y | output | 2 | Destination row |

## Verification
The hardest situation to reach from the ports is the one where the torus wraps. This happens only when an instruction request comes from an edge tile whose rotational ID and address bits make R point off the array, so the neighbour is found on the opposite edge. The bench sweeps every tile through all four values of the address selection bits. This forces every hop direction, including the wrapping ones, from every position. For each request it checks the destination coordinates and also that the destination's rotational ID depends only on the address.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  // Cluster size is fixed at four tiles, two selection bits.
  localparam int CLU_W = 2;

  typedef enum logic [1:0] {
    CLS_INSTR  = 2'b00,
    CLS_PRIV   = 2'b01,
    CLS_SHARED = 2'b10,
    CLS_RSVD   = 2'b11
  } acc_class_e;

  typedef enum logic [1:0] {
    HOP_SELF  = 2'b00,
    HOP_RIGHT = 2'b01,
    HOP_UP    = 2'b10,
    HOP_LEFT  = 2'b11
  } hop_e;
endpackage

// File: rtl/hsp_rid_gen.sv
module hsp_rid_gen
  import hsp_pkg::*;
#(
  parameter int X_W = 2,
  parameter int Y_W = 2
) (
  input  logic [X_W-1:0]   tile_x,
  input  logic [Y_W-1:0]   tile_y,
  output logic [CLU_W-1:0] rid
);
  localparam int TW = X_W + Y_W + CLU_W + 2;

  logic [TW-1:0] mix;

  // Row step of 1, column step of CLU_W (log2 of cluster size).
  assign mix = (TW'(tile_y) * TW'(CLU_W)) - TW'(tile_x);
  assign rid = mix[CLU_W-1:0];

  logic mix_unused;
  assign mix_unused = ^mix[TW-1:CLU_W];
endmodule

// File: rtl/hsp_rot_lookup.sv
module hsp_rot_lookup
  import hsp_pkg::*;
(
  input  logic [CLU_W-1:0] addr_sel,
  input  logic [CLU_W-1:0] rid,
  output hop_e             hop
);
  logic [CLU_W-1:0] rot;

  assign rot = addr_sel + rid + CLU_W'(1);
  assign hop = hop_e'(rot);
endmodule

// File: rtl/hsp_torus_step.sv
module hsp_torus_step
  import hsp_pkg::*;
#(
  parameter int X_W = 2,
  parameter int Y_W = 2
) (
  input  logic [X_W-1:0] cur_x,
  input  logic [Y_W-1:0] cur_y,
  input  hop_e           hop,
  output logic [X_W-1:0] nxt_x,
  output logic [Y_W-1:0] nxt_y
);
  // Power-of-two array: modular wrap falls out of the adder width.
  always_comb begin
    nxt_x = cur_x;
    nxt_y = cur_y;
    case (hop)
      HOP_RIGHT: nxt_x = cur_x + X_W'(1);
      HOP_UP:    nxt_y = cur_y - Y_W'(1);
      HOP_LEFT:  nxt_x = cur_x - X_W'(1);
      default:   ;
    endcase
  end
endmodule

// File: rtl/slice_home_picker.sv
module slice_home_picker
  import hsp_pkg::*;
#(
  parameter int ADDR_W = 42,
  parameter int OFF_W  = 6,
  parameter int SET_W  = 10,
  parameter int X_W    = 2,
  parameter int Y_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_class,
  input  logic [X_W-1:0]    tile_x,
  input  logic [Y_W-1:0]    tile_y,
  output logic [CLU_W-1:0]  rid_out,
  output logic              dst_valid,
  output logic [X_W-1:0]    dst_x,
  output logic [Y_W-1:0]    dst_y
);
  localparam int SEL_LSB = OFF_W + SET_W;
  localparam int SHR_W   = X_W + Y_W;

  acc_class_e       cls;
  hop_e             hop;
  logic [CLU_W-1:0] rid;
  logic [X_W-1:0]   rot_x, nxt_x, dst_x_q;
  logic [Y_W-1:0]   rot_y, nxt_y, dst_y_q;
  logic             vld_q;
  logic             load_en;

  assign cls     = acc_class_e'(req_class);
  assign load_en = req_valid;

  hsp_rid_gen #(.X_W(X_W), .Y_W(Y_W)) rid_i (
    .tile_x (tile_x),
    .tile_y (tile_y),
    .rid    (rid)
  );

  hsp_rot_lookup rot_i (
    .addr_sel (req_addr[SEL_LSB +: CLU_W]),
    .rid      (rid),
    .hop      (hop)
  );

  hsp_torus_step #(.X_W(X_W), .Y_W(Y_W)) step_i (
    .cur_x (tile_x),
    .cur_y (tile_y),
    .hop   (hop),
    .nxt_x (rot_x),
    .nxt_y (rot_y)
  );

  // Next-state selection by access class.
  always_comb begin
    nxt_x = dst_x_q;
    nxt_y = dst_y_q;
    case (cls)
      CLS_PRIV: begin
        nxt_x = tile_x;
        nxt_y = tile_y;
      end
      CLS_INSTR: begin
        nxt_x = rot_x;
        nxt_y = rot_y;
      end
      default: begin
        nxt_x = req_addr[SEL_LSB +: X_W];
        nxt_y = req_addr[SEL_LSB + X_W +: Y_W];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      dst_x_q <= '0;
      dst_y_q <= '0;
    end else begin
      vld_q <= req_valid;
      if (load_en) begin
        dst_x_q <= nxt_x;
        dst_y_q <= nxt_y;
      end
    end
  end

  assign rid_out   = rid;
  assign dst_valid = vld_q;
  assign dst_x     = dst_x_q;
  assign dst_y     = dst_y_q;

  logic addr_unused;
  assign addr_unused = ^{req_addr[ADDR_W-1:SEL_LSB+SHR_W], req_addr[SEL_LSB-1:0]};

  // ---------------- assertions ----------------
  function automatic logic [CLU_W-1:0] rid_of(input logic [X_W-1:0] x,
                                              input logic [Y_W-1:0] y);
    int t;
    t = 2 * int'(y) - int'(x) + 64;
    return t[CLU_W-1:0];
  endfunction

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dst_valid); // R1
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !dst_valid); // R1
  AST_PRIV_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 2'b01) |=>
      (dst_x == $past(tile_x) && dst_y == $past(tile_y))); // R2
  AST_SHARED_STRIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class[1]) |=>
      ({dst_y, dst_x} == $past(req_addr[SEL_LSB +: SHR_W]))); // R3
  AST_INSTR_HOME_RID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 2'b00) |=>
      (rid_of(dst_x, dst_y) == ~$past(req_addr[SEL_LSB +: CLU_W]))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(dst_x) && $stable(dst_y))); // R8
endmodule

// File: tb/slice_home_picker_tb_top.sv
module slice_home_picker_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [41:0] req_addr;
  logic [1:0]  req_class;
  logic [1:0]  tile_x, tile_y;
  logic [1:0]  rid_out;
  logic        dst_valid;
  logic [1:0]  dst_x, dst_y;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  slice_home_picker dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_class (req_class),
    .tile_x    (tile_x),
    .tile_y    (tile_y),
    .rid_out   (rid_out),
    .dst_valid (dst_valid),
    .dst_x     (dst_x),
    .dst_y     (dst_y)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rid_model(input int x, input int y);
    return (2 * y - x + 8) % 4;
  endfunction

  task automatic expect_dest(input int x, input int y, input int cls, input logic [41:0] a,
                             output int ex, output int ey);
    int sel, r;
    sel = int'(a[17:16]);
    ex = x; ey = y;
    if (cls == 1) begin
      ex = x; ey = y;
    end else if (cls == 0) begin
      r = (sel + rid_model(x, y) + 1) % 4;
      case (r)
        1: ex = (x + 1) % 4;
        2: ey = (y + 3) % 4;
        3: ex = (x + 3) % 4;
        default: ;
      endcase
    end else begin
      ex = sel;
      ey = int'(a[19:18]);
    end
  endtask

  // Drive one request at a falling edge; return at the next falling edge.
  task automatic issue(input int x, input int y, input int cls, input logic [41:0] a);
    @(negedge clk);
    tile_x = 2'(x); tile_y = 2'(y); req_class = 2'(cls); req_addr = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "reset dst_valid", int'(dst_valid), 0);
    chk("R1", "reset dst_x", int'(dst_x), 0);
    chk("R1", "reset dst_y", int'(dst_y), 0);
  endtask

  task automatic t_rid();
    for (int y = 0; y < 4; y++)
      for (int x = 0; x < 4; x++) begin
        @(negedge clk);
        tile_x = 2'(x); tile_y = 2'(y);
        #1;
        chk("R6", "rid_out", int'(rid_out), rid_model(x, y));
      end
  endtask

  task automatic t_private();
    int ex, ey;
    for (int y = 0; y < 4; y++)
      for (int x = 0; x < 4; x++) begin
        logic [41:0] a;
        a = 42'h2AB_CDEF_1234 ^ 42'(x * 77 + y * 1311);
        issue(x, y, 1, a);
        expect_dest(x, y, 1, a, ex, ey);
        chk("R1", "private valid", int'(dst_valid), 1);
        chk("R2", "private x", int'(dst_x), ex);
        chk("R2", "private y", int'(dst_y), ey);
      end
  endtask

  task automatic t_shared();
    int ex, ey;
    for (int s = 0; s < 16; s++) begin
      logic [41:0] a;
      a = (42'(s) << 16) | 42'h3_0000_F0A5;
      a[19:16] = 4'(s);
      issue(s % 4, 3 - s / 4, 2, a);
      expect_dest(s % 4, 3 - s / 4, 2, a, ex, ey);
      chk("R3", "shared x", int'(dst_x), ex);
      chk("R3", "shared y", int'(dst_y), ey);
    end
  endtask

  task automatic t_instr();
    int ex, ey, dx, dy, hops;
    for (int y = 0; y < 4; y++)
      for (int x = 0; x < 4; x++)
        for (int s = 0; s < 4; s++) begin
          logic [41:0] a;
          a = 42'h1F_0000_0FC0;
          a[17:16] = 2'(s);
          issue(x, y, 0, a);
          expect_dest(x, y, 0, a, ex, ey);
          chk("R4", "instr x", int'(dst_x), ex);
          chk("R4", "instr y", int'(dst_y), ey);
          chk("R5", "home rid", rid_model(int'(dst_x), int'(dst_y)), 3 - s);
          dx = (int'(dst_x) - x + 4) % 4;
          dy = (int'(dst_y) - y + 4) % 4;
          hops = ((dx == 3) ? 1 : dx) + ((dy == 3) ? 1 : dy);
          chk("R5", "hop distance le 1", int'(hops <= 1), 1);
        end
  endtask

  task automatic t_rsvd();
    int ex, ey;
    logic [41:0] a;
    a = 42'h0;
    a[19:16] = 4'b1001;
    issue(2, 2, 3, a);
    expect_dest(2, 2, 2, a, ex, ey);
    chk("R7", "class 11 x", int'(dst_x), ex);
    chk("R7", "class 11 y", int'(dst_y), ey);
    a[19:16] = 4'b0110;
    issue(0, 1, 3, a);
    expect_dest(0, 1, 2, a, ex, ey);
    chk("R7", "class 11 x b", int'(dst_x), ex);
    chk("R7", "class 11 y b", int'(dst_y), ey);
  endtask

  task automatic t_hold();
    logic [41:0] a;
    a = 42'h0;
    a[19:16] = 4'b1110;
    issue(1, 1, 2, a);
    chk("R1", "valid pulse", int'(dst_valid), 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      req_class = 2'(i); tile_x = 2'(3 - i); tile_y = 2'(i);
      req_addr = ~a ^ 42'(i * 65536);
      chk("R1", "valid idle", int'(dst_valid), 0);
      chk("R8", "hold x", int'(dst_x), 2);
      chk("R8", "hold y", int'(dst_y), 3);
    end
  endtask

  task automatic t_ignored_bits();
    int ex, ey;
    logic [41:0] pats[4];
    pats[0] = 42'h000_0000_0000;
    pats[1] = 42'h3FF_FFF0_FFFF;
    pats[2] = 42'h155_5550_5555;
    pats[3] = 42'h2AA_AAA0_AAAA;
    for (int c = 0; c < 3; c++)
      for (int p = 0; p < 4; p++) begin
        logic [41:0] a;
        a = pats[p];
        a[19:16] = 4'b0111;
        issue(3, 0, c, a);
        expect_dest(3, 0, c, a, ex, ey);
        chk("R9", "ignored bits x", int'(dst_x), ex);
        chk("R9", "ignored bits y", int'(dst_y), ey);
      end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_class = '0;
    tile_x = '0; tile_y = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rid();
    t_private();
    t_shared();
    t_instr();
    t_rsvd();
    t_hold();
    t_ignored_bits();
    finish_run();
  end
endmodule